// File: doc/BRIEF.md
# Common-Stop Pipeline Time-to-Digital Converter

This block timestamps every transition on a set of discriminator hit lines against a free-running coarse counter. One counter tick stands for one time bin of 0.5 ns. Each hit line keeps a short ring of its most recent edges, and entries are discarded once they are older than the look-back window. Both the rising and the falling edge of every pulse are kept.

A rising trigger strobe stops the pipeline for one event. A capture engine then walks each channel's ring. Every edge that lies inside the window before the trigger becomes a 32-bit word, and its time is given as the distance back from the trigger. The event is closed by a trailer word. The engine's dead time depends on how many edges are stored. Edges that arrive during or after the trigger cycle belong to later events.

Events build up in an output buffer that holds up to EVT_MAX events. They are read one word at a time with a pop strobe. A trigger that arrives while the buffer is full, or while a capture is still running, is refused and flagged.

Top module: `tdc_common_stop`

## Requirements
- R1: After reset, valid_o, busy_o and reject_o are low.
- R2: Every change of each hit line is recorded. The edge bit (bit 16) is 1 for a rising edge and 0 for a falling edge.
- R3: The time field (bits 15:0) is the number of clock edges from the edge that samples the hit change to the edge that samples the trigger's rise. An edge is part of the event only if this value is between 1 and WINDOW. An edge sampled on or after the trigger edge is not part of that event.
- R4: A hit word has bit 31 = 0, the channel in bits 27:20, the edge bit in bit 16, the time in bits 15:0, and zeros in all other bits. Each event ends with a trailer word that has bit 31 = 1, the number of hit words of the event in bits 15:0, and zeros elsewhere.
- R5: Hit words of an event come in ascending channel order. Within a channel they come oldest edge first.
- R6: Each channel keeps only its HIT_DEPTH most recent edges. A newer edge overwrites the oldest one.
- R7: The buffer holds up to EVT_MAX events whose trailers have not yet been read. A trigger arriving while EVT_MAX events are held produces no event, and reject_o goes high for one cycle.
- R8: busy_o is high from the edge after an accepted trigger for sum over channels of (stored edges + 1) plus 1 cycles. A trigger that rises while busy_o is high is refused in the same way as in R7.
- R9: While valid_o is high, word_o shows the oldest unread word, and rd_i removes it on the next edge. rd_i while valid_o is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one tick per time bin |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hit_i | input | N_CH | Discriminator lines, synchronous to clk_i |
| trig_i | input | 1 | Trigger strobe, acts on its rising edge |
| rd_i | input | 1 | Pop one output word |
| word_o | output | 32 | Oldest unread word |
| valid_o | output | 1 | word_o holds data |
| busy_o | output | 1 | Capture in progress |
| reject_o | output | 1 | One-cycle pulse for a refused trigger |

## Verification
The hardest situations to reach are the exact window edge and the full buffer. At the window edge, an edge WINDOW ticks old must be kept while its partner one tick older is dropped. When the buffer is full, the ninth trigger must leave no trace. The bench keeps its own tick counter, which advances on every falling clock edge at which it drives the inputs, and computes every expected time as the difference of two counter values. It produces eight empty events without reading any of them, then refuses the ninth. A second trigger is timed to rise two cycles into a capture, which exercises the dead-time refusal.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int WORD_W = 32;
  localparam int TIME_W = 16;

  typedef enum logic [1:0] {CAP_IDLE, CAP_SCAN, CAP_TRAIL} cap_state_e;

  function automatic logic [WORD_W-1:0] hit_word(input logic [7:0] ch, input logic rise,
                                                 input logic [TIME_W-1:0] t);
    return {4'b0000, ch, 3'b000, rise, t};
  endfunction

  function automatic logic [WORD_W-1:0] trailer_word(input logic [TIME_W-1:0] n);
    return {1'b1, 15'd0, n};
  endfunction
endpackage

// File: rtl/tdc_edge_ring.sv
module tdc_edge_ring #(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 17,
  parameter int WINDOW = 64000,
  localparam int IW = $clog2(DEPTH),
  localparam int FW = IW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic             rd_rise_o,
  output logic [CNT_W-1:0] rd_ts_o,
  output logic [IW-1:0]    head_o,
  output logic [FW-1:0]    fill_o
);
  localparam logic [CNT_W-1:0] WIN  = CNT_W'(WINDOW);
  localparam logic [FW-1:0]    FULL = FW'(DEPTH);

  logic             hit_q;
  logic [IW-1:0]    wp;
  logic [FW-1:0]    fill;
  logic [CNT_W-1:0] ts_mem [DEPTH];
  logic             rise_mem [DEPTH];
  logic             edge_seen, expire;
  logic [IW-1:0]    oldest;
  logic [CNT_W-1:0] age;

  assign edge_seen = hit_i ^ hit_q;
  assign oldest    = wp - fill[IW-1:0];
  assign age       = cnt_i - ts_mem[oldest];
  // only the oldest entry can leave the window, one per cycle
  assign expire    = (fill != '0) && (age > WIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      wp    <= '0;
      fill  <= '0;
    end else begin
      hit_q <= hit_i;
      if (edge_seen) wp <= wp + 1'b1;
      if (edge_seen && !expire && fill != FULL) fill <= fill + 1'b1;
      else if (!edge_seen && expire)            fill <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (edge_seen) begin
      ts_mem[wp]   <= cnt_i;
      rise_mem[wp] <= hit_i;
    end
  end

  assign rd_rise_o = rise_mem[rd_idx_i];
  assign rd_ts_o   = ts_mem[rd_idx_i];
  assign head_o    = oldest;
  assign fill_o    = fill;

  // R6
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) fill <= FULL);
  // R2
  edge_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                   edge_seen |=> fill != '0);
endmodule

// File: rtl/tdc_word_fifo.sv
module tdc_word_fifo #(
  parameter int W         = 32,
  parameter int DEPTH_MIN = 264,
  localparam int AW = $clog2(DEPTH_MIN),
  localparam int N  = 2 ** AW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o
);
  logic [W-1:0]  mem [N];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          full;

  assign full    = cnt == (AW+1)'(N);
  assign empty_o = cnt == '0;
  assign dout_o  = mem[rp];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_i) wp <= wp + 1'b1;
      if (pop_i)  rp <= rp + 1'b1;
      if (push_i && !pop_i)      cnt <= cnt + 1'b1;
      else if (!push_i && pop_i) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp] <= din_i;
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) push_i |-> !full);
endmodule

// File: rtl/tdc_capture.sv
module tdc_capture import tdc_pkg::*; #(
  parameter int N_CH    = 4,
  parameter int DEPTH   = 8,
  parameter int CNT_W   = 17,
  parameter int WINDOW  = 64000,
  parameter int EVT_MAX = 8,
  localparam int IW  = $clog2(DEPTH),
  localparam int FW  = IW + 1,
  localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int EW  = $clog2(EVT_MAX + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       trig_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [N_CH-1:0][FW-1:0]    fill_i,
  input  logic [N_CH-1:0][IW-1:0]    head_i,
  input  logic [N_CH-1:0]            rise_i,
  input  logic [N_CH-1:0][CNT_W-1:0] ts_i,
  input  logic                       trail_pop_i,
  output logic [IW-1:0]              rd_idx_o,
  output logic                       wr_o,
  output logic [WORD_W-1:0]          wr_word_o,
  output logic                       busy_o,
  output logic                       reject_o
);
  localparam logic [CNT_W-1:0] WIN = CNT_W'(WINDOW);

  cap_state_e              state;
  logic                    trig_q, trig_rise, accept;
  logic [CNT_W-1:0]        t_trig, rel;
  logic [N_CH-1:0][FW-1:0] fill_snap;
  logic [N_CH-1:0][IW-1:0] head_snap;
  logic [CHW-1:0]          ch;
  logic [FW-1:0]           j;
  logic [TIME_W-1:0]       nhit;
  logic [EW-1:0]           evt_cnt;
  logic                    in_chan, in_win;

  assign trig_rise = trig_i & ~trig_q;
  assign accept    = trig_rise && (state == CAP_IDLE) && (evt_cnt < EW'(EVT_MAX));
  assign busy_o    = state != CAP_IDLE;
  assign in_chan   = j < fill_snap[ch];
  assign rel       = t_trig - ts_i[ch];
  // entries overwritten after the stop wrap to a large distance and fall out here
  assign in_win    = (rel != '0) && (rel <= WIN);
  assign rd_idx_o  = head_snap[ch] + j[IW-1:0];
  assign wr_o      = ((state == CAP_SCAN) && in_chan && in_win) || (state == CAP_TRAIL);
  assign wr_word_o = (state == CAP_TRAIL) ? trailer_word(nhit)
                                          : hit_word(8'(ch), rise_i[ch], TIME_W'(rel));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= CAP_IDLE;
      trig_q    <= 1'b0;
      t_trig    <= '0;
      fill_snap <= '0;
      head_snap <= '0;
      ch        <= '0;
      j         <= '0;
      nhit      <= '0;
      evt_cnt   <= '0;
      reject_o  <= 1'b0;
    end else begin
      trig_q   <= trig_i;
      reject_o <= trig_rise && !accept;
      if (accept && !trail_pop_i)      evt_cnt <= evt_cnt + 1'b1;
      else if (!accept && trail_pop_i) evt_cnt <= evt_cnt - 1'b1;
      case (state)
        CAP_IDLE: if (accept) begin
          t_trig    <= cnt_i;
          fill_snap <= fill_i;
          head_snap <= head_i;
          ch        <= '0;
          j         <= '0;
          nhit      <= '0;
          state     <= CAP_SCAN;
        end
        CAP_SCAN: if (in_chan) begin
          j <= j + 1'b1;
          if (in_win) nhit <= nhit + 1'b1;
        end else if (ch == CHW'(N_CH - 1)) begin
          state <= CAP_TRAIL;
        end else begin
          ch <= ch + 1'b1;
          j  <= '0;
        end
        default: state <= CAP_IDLE;
      endcase
    end
  end

  // R7
  evt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                  evt_cnt <= EW'(EVT_MAX));
  // R3
  win_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                  (wr_o && !wr_word_o[31]) |->
                                  (wr_word_o[15:0] != '0 && 32'(wr_word_o[15:0]) <= WINDOW));
  // R8
  busy_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                    (trig_rise && busy_o) |=> reject_o);
  // R8
  trail_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                  (state == CAP_TRAIL) |=> !busy_o);
endmodule

// File: rtl/tdc_common_stop.sv
module tdc_common_stop import tdc_pkg::*; #(
  parameter int N_CH      = 4,
  parameter int HIT_DEPTH = 8,
  parameter int WINDOW    = 64000,
  parameter int EVT_MAX   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   hit_i,
  input  logic              trig_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              reject_o
);
  localparam int IW       = $clog2(HIT_DEPTH);
  localparam int FW       = IW + 1;
  // wide enough that post-stop entries wrap far beyond the window
  localparam int CNT_W    = $clog2(2 * WINDOW + 2 * N_CH * (HIT_DEPTH + 1) + 8);
  localparam int FIFO_MIN = EVT_MAX * (N_CH * HIT_DEPTH + 1);

  logic [CNT_W-1:0]           cnt;
  logic [N_CH-1:0][FW-1:0]    fill_w;
  logic [N_CH-1:0][IW-1:0]    head_w;
  logic [N_CH-1:0]            rise_w;
  logic [N_CH-1:0][CNT_W-1:0] ts_w;
  logic [IW-1:0]              rd_idx;
  logic                       wr;
  logic [WORD_W-1:0]          wr_word;
  logic                       empty, pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else         cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ring
    tdc_edge_ring #(.DEPTH(HIT_DEPTH), .CNT_W(CNT_W), .WINDOW(WINDOW)) u_ring (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (hit_i[g]),
      .cnt_i    (cnt),
      .rd_idx_i (rd_idx),
      .rd_rise_o(rise_w[g]),
      .rd_ts_o  (ts_w[g]),
      .head_o   (head_w[g]),
      .fill_o   (fill_w[g])
    );
  end

  tdc_capture #(.N_CH(N_CH), .DEPTH(HIT_DEPTH), .CNT_W(CNT_W), .WINDOW(WINDOW),
                .EVT_MAX(EVT_MAX)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .cnt_i      (cnt),
    .fill_i     (fill_w),
    .head_i     (head_w),
    .rise_i     (rise_w),
    .ts_i       (ts_w),
    .trail_pop_i(pop & word_o[31]),
    .rd_idx_o   (rd_idx),
    .wr_o       (wr),
    .wr_word_o  (wr_word),
    .busy_o     (busy_o),
    .reject_o   (reject_o)
  );

  assign pop     = rd_i & ~empty;
  assign valid_o = ~empty;

  tdc_word_fifo #(.W(WORD_W), .DEPTH_MIN(FIFO_MIN)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (wr),
    .din_i  (wr_word),
    .pop_i  (pop),
    .dout_o (word_o),
    .empty_o(empty)
  );
endmodule

// File: tb/sim_tdc_common_stop.sv
module sim_tdc_common_stop;
  localparam int NC = 4;
  localparam int HD = 4;
  localparam int W  = 100;
  localparam int EM = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC-1:0] hit;
  logic          trig, rd;
  logic [31:0]   word;
  logic          valid, busy, reject;
  int total = 0, bad = 0, now = 0;

  always #2 clk = ~clk;

  tdc_common_stop #(.N_CH(NC), .HIT_DEPTH(HD), .WINDOW(W), .EVT_MAX(EM)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .trig_i(trig), .rd_i(rd),
    .word_o(word), .valid_o(valid), .busy_o(busy), .reject_o(reject)
  );

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); now++; end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hw(input int ch, input bit rise, input int t);
    return {4'b0000, 8'(ch), 3'b000, rise, 16'(t)};
  endfunction

  function automatic logic [31:0] tw(input int n);
    return {1'b1, 15'd0, 16'(n)};
  endfunction

  task automatic pop_word(input logic [31:0] exp, input string req);
    chk(valid === 1'b1 && word === exp, req, valid ? word : 32'hxxxx_xxxx, exp);
    rd = 1'b1; tick(1); rd = 1'b0;
  endtask

  task automatic trig_pulse();
    trig = 1'b1; tick(1); trig = 1'b0;
  endtask

  task automatic wait_idle(output int len);
    len = 0;
    while (busy && len < 1000) begin len++; tick(1); end
  endtask

  task automatic flush();
    tick(W + 4);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hit = '0; trig = 1'b0; rd = 1'b0;
    tick(3); rst_n = 1'b1; tick(1);
    chk(!valid && !busy && !reject, "R1 reset", {29'd0, valid, busy, reject}, 32'd0);
  endtask

  task automatic t_single();
    int a, b, t, len;
    flush();
    a = now; hit[1] = 1'b1; tick(5);
    b = now; hit[1] = 1'b0; tick(5);
    t = now; trig_pulse(); wait_idle(len);
    chk(len == 7, "R8 dead time single", len, 7);
    pop_word(hw(1, 1, t - a), "R2 R3 rising word");
    pop_word(hw(1, 0, t - b), "R2 R3 falling word");
    pop_word(tw(2), "R4 trailer");
    chk(!valid, "R9 drained", valid, 0);
  endtask

  task automatic t_multi();
    int len;
    flush();
    hit[2] = 1'b1; tick(3);
    hit[0] = 1'b1; tick(2);
    hit[2] = 1'b0; tick(4);
    hit[0] = 1'b0; tick(1);
    trig_pulse(); wait_idle(len);
    chk(len == 9, "R8 dead time multi", len, 9);
    pop_word(hw(0, 1, 7), "R5 ch0 rise first");
    pop_word(hw(0, 0, 1), "R5 ch0 fall");
    pop_word(hw(2, 1, 10), "R5 ch2 rise");
    pop_word(hw(2, 0, 5), "R5 ch2 fall");
    pop_word(tw(4), "R4 trailer multi");
  endtask

  task automatic t_window();
    int len;
    flush();
    hit[1] = 1'b1; tick(1);
    hit[1] = 1'b0; tick(W);
    trig_pulse(); wait_idle(len);
    pop_word(hw(1, 0, W), "R3 edge at window kept");
    pop_word(tw(1), "R3 older edge dropped");
  endtask

  task automatic t_same_cycle();
    int a, b, t, len;
    flush();
    a = now; hit[3] = 1'b1; trig = 1'b1; tick(1); trig = 1'b0;
    tick(3);
    b = now; hit[3] = 1'b0;
    wait_idle(len); tick(2);
    pop_word(tw(0), "R3 same-cycle edge excluded");
    t = now; trig_pulse(); wait_idle(len);
    pop_word(hw(3, 1, t - a), "R3 next event rise");
    pop_word(hw(3, 0, t - b), "R3 next event fall");
    pop_word(tw(2), "R3 next event trailer");
  endtask

  task automatic t_overflow();
    int e[6];
    int t, len;
    flush();
    for (int i = 0; i < 6; i++) begin
      e[i] = now; hit[0] = ~hit[0]; tick(2);
    end
    t = now; trig_pulse(); wait_idle(len);
    chk(len == 9, "R8 dead time full ring", len, 9);
    pop_word(hw(0, 1, t - e[2]), "R6 newest four kept");
    pop_word(hw(0, 0, t - e[3]), "R6 second");
    pop_word(hw(0, 1, t - e[4]), "R6 third");
    pop_word(hw(0, 0, t - e[5]), "R6 fourth");
    pop_word(tw(4), "R6 trailer");
  endtask

  task automatic t_empty_read();
    int len;
    flush();
    rd = 1'b1; tick(2); rd = 1'b0;
    chk(!valid, "R9 pop on empty ignored", valid, 0);
    trig_pulse(); wait_idle(len);
    pop_word(tw(0), "R9 buffer intact");
    chk(!valid, "R9 single word", valid, 0);
  endtask

  task automatic t_full();
    int len;
    flush();
    for (int i = 0; i < EM; i++) begin
      trig_pulse(); wait_idle(len); tick(1);
    end
    trig_pulse();
    chk(reject === 1'b1, "R7 full buffer reject", reject, 1);
    tick(1);
    chk(!busy && !reject, "R7 no capture when full", {busy, reject}, 0);
    for (int i = 0; i < EM; i++) pop_word(tw(0), "R7 stored trailer");
    chk(!valid, "R7 refused event absent", valid, 0);
    trig_pulse();
    chk(reject === 1'b0, "R7 accept after drain", reject, 0);
    wait_idle(len);
    pop_word(tw(0), "R7 new event");
  endtask

  task automatic t_dead();
    int a, b, t, len;
    flush();
    a = now; hit[2] = 1'b1; tick(2);
    b = now; hit[2] = 1'b0; tick(3);
    t = now; trig = 1'b1; tick(1); trig = 1'b0; tick(1); trig = 1'b1; tick(1);
    chk(reject === 1'b1, "R8 trigger during capture refused", reject, 1);
    trig = 1'b0;
    wait_idle(len);
    pop_word(hw(2, 1, t - a), "R8 first event rise");
    pop_word(hw(2, 0, t - b), "R8 first event fall");
    pop_word(tw(2), "R8 first event trailer");
    chk(!valid, "R8 no second event", valid, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_window();
    t_same_cycle();
    t_overflow();
    t_empty_read();
    t_full();
    t_dead();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule